// File: doc/BRIEF.md
# Variable Pulse Width Bus Transmitter

This block drives a single-wire bus on which every symbol is a pulse whose width carries the meaning. The line toggles between an active and a passive level at every symbol boundary. A data bit is read from its width together with the level it occupies: a short pulse means one thing while the line is passive and the opposite while it is active. The block turns a byte stream into that pulse train. It frames the stream with a long active opening pulse and a long passive closing gap, then holds the line quiet for a separation period before another frame may begin.

All durations are counted in ticks of an external 1 µs enable strobe. The host raises `tx_start` while the block is idle and then supplies bytes through a valid/ready handshake. It marks the final byte with `tx_last`. A second byte can be handed over while the first is still being sent, so consecutive bytes leave no gap on the line. A break request aborts whatever is in progress and drives a long active pulse. The block reports the end of every normally completed frame with a one-cycle pulse.

Top module: `vpw_tx`

## Requirements
- R1: After reset `bus_active`, `tx_ready` and `frame_done` are all 0 and the block is idle.
- R2: `tx_start` while idle drives `bus_active` to 1 on the next clock edge and holds it there for T_SOF ticks. `tx_start` at any other time has no effect.
- R3: The width of a data bit is set by the bit and the level it is sent at. A 0 is T_SHORT ticks when passive and T_LONG ticks when active. A 1 is T_LONG ticks when passive and T_SHORT ticks when active.
- R4: Bits leave most significant bit first. The first data bit of a frame is passive, the level toggles at every bit boundary, and consecutive bytes follow with no extra symbol between them.
- R5: `tx_ready` is high only while the opening pulse or data bits are being sent, no byte is waiting, and the final byte has not yet been taken. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. Once a byte flagged `tx_last` has been taken, `tx_ready` stays low for the rest of the frame.
- R6: When a byte finishes and no further byte is waiting, the line goes passive. `frame_done` then pulses high for exactly one cycle, T_EOD + T_EOF_EXT ticks after the line went passive.
- R7: After `frame_done` the line stays passive for a further T_IFS ticks, and `tx_start` during that time is ignored.
- R8: `brk_req` outside a break drives `bus_active` to 1 on the next edge for T_BRK ticks, then passive for T_IFS ticks. Any waiting byte is discarded, `tx_ready` stays low, and no `frame_done` is produced.
- R9: Segment widths advance only on clock edges where `tick` is high. A symbol that starts on a tick lasts exactly its width times the tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 1 µs enable strobe, one cycle wide |
| tx_start | input | 1 | Begin a frame (honoured only when idle) |
| tx_byte | input | DATA_W | Byte offered for transmission |
| tx_valid | input | 1 | `tx_byte` is valid |
| tx_last | input | 1 | Offered byte is the final one of the frame |
| brk_req | input | 1 | Abort and send a break pulse |
| tx_ready | output | 1 | Block can take a byte this cycle |
| frame_done | output | 1 | One-cycle pulse at the end of a completed frame |
| bus_active | output | 1 | Line level: 1 active, 0 passive |

## Verification
Nearly every internal fault reaches the line within one symbol. A wrong level flag, a bad bit counter or a misloaded shift register shows up as a pulse of the wrong width or polarity on `bus_active`, and that wrong pulse ends at the very next boundary. A lost or stuck byte-hold flag shows within one byte time: either the frame closes early with a passive gap, or `tx_ready` fails to rise or fall at the right edge. Errors in the closing sequencer move `frame_done` off its fixed offset from the last falling edge, or let a start request through during the separation gap. The bench therefore decodes every pulse width over all byte values and times the closing edges to the cycle.

// File: rtl/vpw_tx_pkg.sv
package vpw_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF,
        ST_BITS,
        ST_EOD,
        ST_EOF,
        ST_IFS,
        ST_BRK
    } vpw_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vpw_seg_timer.sv
module vpw_seg_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // Counts down one per tick; the segment ends on the tick that consumes the last unit.
    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    assign expire = tick && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/vpw_byte_hold.sv
module vpw_byte_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open,
    input  logic              flush,
    input  logic              take,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              ready,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        logic              full;
        logic              closed;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t h_d, h_q;

    assign ready = open && !h_q.full && !h_q.closed;

    always_comb begin
        h_d = h_q;
        if (flush) begin
            h_d.full   = 1'b0;
            h_d.closed = 1'b0;
        end else begin
            if (take) begin
                h_d.full = 1'b0;
            end
            if (ready && in_valid) begin
                h_d.full   = 1'b1;
                h_d.data   = in_data;
                h_d.closed = in_last;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '{full: 1'b0, closed: 1'b0, data: '0};
        end else begin
            h_q <= h_d;
        end
    end

    assign full = h_q.full;
    assign data = h_q.data;

endmodule

// File: rtl/vpw_tx.sv
module vpw_tx
    import vpw_tx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int T_SHORT   = 64,
    parameter int T_LONG    = 128,
    parameter int T_SOF     = 200,
    parameter int T_EOD     = 200,
    parameter int T_EOF_EXT = 80,
    parameter int T_BRK     = 280,
    parameter int T_IFS     = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_valid,
    input  logic              tx_last,
    input  logic              brk_req,
    output logic              tx_ready,
    output logic              frame_done,
    output logic              bus_active
);

    localparam int T_MAX = imax(imax(imax(T_SHORT, T_LONG), imax(T_SOF, T_EOD)),
                                imax(imax(T_EOF_EXT, T_BRK), T_IFS));
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    localparam logic [CNT_W-1:0] L_SHORT = CNT_W'(T_SHORT);
    localparam logic [CNT_W-1:0] L_LONG  = CNT_W'(T_LONG);
    localparam logic [CNT_W-1:0] L_SOF   = CNT_W'(T_SOF);
    localparam logic [CNT_W-1:0] L_EOD   = CNT_W'(T_EOD);
    localparam logic [CNT_W-1:0] L_EXT   = CNT_W'(T_EOF_EXT);
    localparam logic [CNT_W-1:0] L_BRK   = CNT_W'(T_BRK);
    localparam logic [CNT_W-1:0] L_IFS   = CNT_W'(T_IFS);
    localparam logic [BIT_W-1:0] L_LEFT  = BIT_W'(DATA_W - 1);

    typedef struct packed {
        vpw_state_e        st;
        logic              lvl;
        logic [DATA_W-1:0] sh;
        logic [BIT_W-1:0]  left;
        logic              done;
    } ctl_t;

    ctl_t r_d, r_q;

    logic             seg_end;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             take;
    logic             flush;
    logic             hold_open;
    logic             hold_ready;
    logic             hold_full;
    logic [DATA_W-1:0] hold_data;
    logic             byte_end;

    // Width depends on the bit and on the level it will occupy.
    function automatic logic [CNT_W-1:0] width_of(input logic b, input logic act);
        return (b ^ act) ? L_LONG : L_SHORT;
    endfunction

    vpw_seg_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (load),
        .load_val (load_val),
        .expire   (seg_end)
    );

    assign hold_open = (r_q.st == ST_SOF) || (r_q.st == ST_BITS);

    vpw_byte_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .open     (hold_open),
        .flush    (flush),
        .take     (take),
        .in_valid (tx_valid),
        .in_data  (tx_byte),
        .in_last  (tx_last),
        .ready    (hold_ready),
        .full     (hold_full),
        .data     (hold_data)
    );

    assign byte_end = (r_q.st == ST_SOF) || (r_q.left == '0);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        load     = 1'b0;
        load_val = L_SHORT;
        take     = 1'b0;
        flush    = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (tx_start) begin
                    r_d.st   = ST_SOF;
                    r_d.lvl  = 1'b1;
                    load     = 1'b1;
                    load_val = L_SOF;
                    flush    = 1'b1;
                end
            end
            ST_SOF, ST_BITS: begin
                if (seg_end) begin
                    r_d.lvl = ~r_q.lvl;
                    load    = 1'b1;
                    if (byte_end) begin
                        if (hold_full) begin
                            take     = 1'b1;
                            r_d.st   = ST_BITS;
                            r_d.sh   = hold_data << 1;
                            r_d.left = L_LEFT;
                            load_val = width_of(hold_data[DATA_W-1], ~r_q.lvl);
                        end else begin
                            r_d.st   = ST_EOD;
                            r_d.lvl  = 1'b0;
                            load_val = L_EOD;
                        end
                    end else begin
                        r_d.sh   = r_q.sh << 1;
                        r_d.left = r_q.left - 1'b1;
                        load_val = width_of(r_q.sh[DATA_W-1], ~r_q.lvl);
                    end
                end
            end
            ST_EOD: begin
                if (seg_end) begin
                    r_d.st   = ST_EOF;
                    load     = 1'b1;
                    load_val = L_EXT;
                end
            end
            ST_EOF: begin
                if (seg_end) begin
                    r_d.st   = ST_IFS;
                    r_d.done = 1'b1;
                    load     = 1'b1;
                    load_val = L_IFS;
                end
            end
            ST_IFS: begin
                if (seg_end) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_BRK: begin
                if (seg_end) begin
                    r_d.st   = ST_IFS;
                    r_d.lvl  = 1'b0;
                    load     = 1'b1;
                    load_val = L_IFS;
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.lvl = 1'b0;
            end
        endcase

        // Break overrides every other activity.
        if (brk_req && (r_q.st != ST_BRK)) begin
            r_d.st   = ST_BRK;
            r_d.lvl  = 1'b1;
            r_d.done = 1'b0;
            load     = 1'b1;
            load_val = L_BRK;
            flush    = 1'b1;
            take     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, lvl: 1'b0, sh: '0, left: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_active = r_q.lvl;
    assign frame_done = r_q.done;
    assign tx_ready   = hold_ready;

endmodule

// File: rtl/vpw_tx_chk.sv
module vpw_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic tx_start,
    input logic brk_req,
    input logic tx_ready,
    input logic frame_done,
    input logic bus_active
);

    // R6: completion is a single-cycle pulse
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R6: completion only with the line passive and no byte being taken
    a_r6_done_passive: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!bus_active && !tx_ready));

    // R9: without tick, start or break the line level cannot move
    a_r9_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !tx_start && !brk_req) |=> $stable(bus_active));

    // R2: every rising edge of the line has a cause
    a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_active) |-> $past(tx_start || brk_req || tick));

    // R8: a break drives the line active and closes the byte path
    a_r8_brk_drive: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> (bus_active && !tx_ready && !frame_done));

    // R7: after completion the line stays passive
    a_r7_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !bus_active);

endmodule

bind vpw_tx vpw_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .tx_start   (tx_start),
    .brk_req    (brk_req),
    .tx_ready   (tx_ready),
    .frame_done (frame_done),
    .bus_active (bus_active)
);

// File: tb/vpw_tx_test.sv
module vpw_tx_test;

    localparam int SH   = 4;
    localparam int LG   = 8;
    localparam int SF   = 12;
    localparam int ED   = 12;
    localparam int EX   = 5;
    localparam int BK   = 17;
    localparam int IFSL = 18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       tx_start = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_last = 1'b0;
    logic       brk_req = 1'b0;
    logic       tx_ready;
    logic       frame_done;
    logic       bus_active;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0] q_data [0:15];
    int  q_n = 0;
    int  q_idx = 0;
    bit  feed_en = 1'b0;
    bit  hs_flag = 1'b0;
    int  tick_div = 1;
    int  tick_cnt = 0;

    vpw_tx #(
        .DATA_W(8), .T_SHORT(SH), .T_LONG(LG), .T_SOF(SF), .T_EOD(ED),
        .T_EOF_EXT(EX), .T_BRK(BK), .T_IFS(IFSL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_start(tx_start),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_last(tx_last),
        .brk_req(brk_req), .tx_ready(tx_ready), .frame_done(frame_done),
        .bus_active(bus_active)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog (run hung): actual %0d expected below 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Tick strobe and byte feeder, updated shortly after each falling edge.
    always begin
        @(negedge clk);
        #1;
        tick_cnt = (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
        tick = (tick_cnt == 0);
        if (hs_flag) begin
            q_idx++;
            if (q_idx == q_n) chk(tx_ready == 1'b0, "R5 ready low after final byte", tx_ready, 0);
        end
        hs_flag = 1'b0;
        if (feed_en && (q_idx < q_n)) begin
            tx_valid = 1'b1;
            tx_byte  = q_data[q_idx];
            tx_last  = (q_idx == q_n - 1);
        end else begin
            tx_valid = 1'b0;
            tx_last  = 1'b0;
        end
        hs_flag = tx_valid && tx_ready;
    end

    task automatic next_run(input bit lvl, output int len);
        bit go = 1'b1;
        len = 1;
        while (go) begin
            @(negedge clk);
            if (bus_active == lvl && len < 4000) len++;
            else go = 1'b0;
        end
    endtask

    task automatic idle_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic start_frame(input int n, input int div);
        tick_div = div;
        q_idx    = 0;
        q_n      = n;
        feed_en  = 1'b1;
        @(negedge clk);
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        chk(bus_active == 1'b1, "R2 start raises line", bus_active, 1);
    endtask

    task automatic run_frame(input int n, input int div, input bit mid_start);
        int len;
        int k_done;
        int bad_bus;
        int done_at;
        int done_cnt;
        bit lvl;
        bit b;
        int exp;
        start_frame(n, div);
        next_run(1'b1, len);
        if (div == 1) chk(len == SF, "R2 start pulse width", len, SF);
        lvl = 1'b0;
        for (int k = 0; k < n; k++) begin
            for (int j = 7; j >= 0; j--) begin
                b   = q_data[k][j];
                exp = ((b ^ lvl) ? LG : SH) * div;
                chk(bus_active == lvl, "R4 bit level order", bus_active, lvl);
                if (mid_start && k == 0 && j == 4) tx_start = 1'b1;
                next_run(lvl, len);
                tx_start = 1'b0;
                chk(len == exp, (div == 1) ? "R3 bit width" : "R9 bit width with tick gaps", len, exp);
                lvl = ~lvl;
            end
        end
        // Closing gap: end of data, end of frame, separation.
        k_done   = (ED + EX) * div;
        bad_bus  = 0;
        done_at  = -1;
        done_cnt = 0;
        for (int c = 1; c <= k_done + IFSL * div; c++) begin
            if (c > 1) @(negedge clk);
            if (bus_active != 1'b0) bad_bus++;
            if (frame_done) begin
                done_cnt++;
                if (done_at < 0) done_at = c;
            end
            tx_start = (c == k_done + 2);
        end
        tx_start = 1'b0;
        feed_en  = 1'b0;
        chk(done_at == k_done + 1, "R6 completion offset", done_at, k_done + 1);
        chk(done_cnt == 1, "R6 completion single pulse", done_cnt, 1);
        chk(bad_bus == 0, "R7 passive through separation, start ignored", bad_bus, 0);
        idle_wait(3);
        tick_div = 1;
    endtask

    task automatic check_break_tail();
        int len;
        int bad;
        @(negedge clk);
        brk_req = 1'b0;
        chk(bus_active == 1'b1, "R8 break raises line", bus_active, 1);
        next_run(1'b1, len);
        chk(len == BK, "R8 break width", len, BK);
        bad = 0;
        for (int c = 1; c <= IFSL; c++) begin
            if (c > 1) @(negedge clk);
            if (bus_active || frame_done || tx_ready) bad++;
        end
        chk(bad == 0, "R8 passive after break, no completion, no ready", bad, 0);
        idle_wait(3);
    endtask

    initial begin
        int len;
        // R1: reset state
        idle_wait(3);
        chk(bus_active == 1'b0, "R1 reset line passive", bus_active, 0);
        chk(tx_ready == 1'b0, "R1 reset ready low", tx_ready, 0);
        chk(frame_done == 1'b0, "R1 reset no completion", frame_done, 0);
        rst_n = 1'b1;
        idle_wait(3);
        chk(bus_active == 1'b0 && tx_ready == 1'b0, "R1 idle after reset", bus_active, 0);

        // R3 R4 R6: every byte value in a one-byte frame
        for (int v = 0; v < 256; v++) begin
            q_data[0] = v[7:0];
            run_frame(1, 1, 1'b0);
        end

        // R4 R5: back-to-back bytes, with a stray start mid-frame (R2)
        q_data[0] = 8'hA5; q_data[1] = 8'h3C; q_data[2] = 8'hFF; q_data[3] = 8'h01;
        run_frame(4, 1, 1'b1);

        // R6: frame with no byte supplied
        run_frame(0, 1, 1'b0);

        // R9: tick every third cycle
        q_data[0] = 8'h96; q_data[1] = 8'h5A;
        run_frame(2, 3, 1'b0);

        // R8: break in the middle of a frame
        for (int i = 0; i < 4; i++) q_data[i] = 8'h00;
        start_frame(4, 1);
        next_run(1'b1, len);
        next_run(1'b0, len);
        chk(len == SH, "R3 passive zero width", len, SH);
        next_run(1'b1, len);
        chk(len == LG, "R3 active zero width", len, LG);
        brk_req = 1'b1;
        feed_en = 1'b0;
        check_break_tail();

        // R8: break from idle, then normal operation resumes
        @(negedge clk);
        brk_req = 1'b1;
        check_break_tail();
        q_data[0] = 8'hC3;
        run_frame(1, 1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule